// File: doc/BRIEF.md
# Boot Image Copier

This block loads a program into a target processor at boot. When a GO strobe arrives while the block is idle, it reads a length header from the start of an image held in a byte-wide source memory. It then copies that many payload bytes, one at a time, into consecutive addresses of the target's memory. After the last byte has been accepted, it raises a run signal together with the fixed entry address, which releases the target to execute the new program.

The source memory has a synchronous read port. Data requested in one cycle is returned in the next cycle. The target side is a single-byte write port with a ready input. A write is held until the target accepts it. If the header gives a length that cannot fit in the image region, the copy is refused: an error flag is raised and the target is never started.

Top module: `boot_copier`

## Requirements
- R1: While reset is held and after it is released, busy, done, error, run, tgt_we and src_rd_en are all low.
- R2: A GO pulse while idle starts a copy, and busy is high from the following cycle. The header is read from source offsets 0..3 and is little-endian: the byte at offset 0 is the least significant.
- R3: Payload bytes are taken from source offset 4 onward, in ascending order. The first byte is written to target address 0x40200000 and each following byte to the next address up.
- R4: A target write counts only in a cycle where tgt_we and tgt_ready are both high. While tgt_ready is low, tgt_we, tgt_addr and tgt_wdata stay unchanged.
- R5: After exactly the header's number of bytes has been written, busy falls and done and run rise, with run_addr equal to 0x40200000.
- R6: A header length of zero causes no target writes and raises done and run directly.
- R7: A header length above 57340 (the 56 kB region minus the 4-byte header) raises error and done. In that case there are no target writes, run stays low and no source read goes outside the region.
- R8: A GO pulse while busy has no effect: the copy in progress keeps its address sequence and byte count.
- R9: A GO pulse after a finished copy clears run, done and error on the next cycle and starts a new copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start strobe |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Last copy finished (success or error) |
| error | output | 1 | Last copy refused: length out of range |
| src_rd_en | output | 1 | Source read request |
| src_addr | output | 16 | Source byte offset |
| src_rd_data | input | 8 | Source data, valid the cycle after the request |
| tgt_we | output | 1 | Target write valid |
| tgt_addr | output | 32 | Target byte address |
| tgt_wdata | output | 8 | Target write byte |
| tgt_ready | input | 1 | Target accepts the write this cycle |
| run | output | 1 | Target released to execute |
| run_addr | output | 32 | Execution entry address |

## Verification
The bench uses a length whose two low header bytes are both non-zero. A copier that assembled the header big-endian would read a huge length, flag an error and write nothing. Random ready stalls check that a write is neither dropped nor duplicated, and that a design which advanced on tgt_we alone would show up as a shifted byte stream. The bench also pulses GO in the middle of a copy, which catches a design that restarts at 0x40200000. A zero length and a length one above the limit check that the design neither writes a byte it should not nor starts a target it should have refused.

// File: rtl/boot_copier_pkg.sv
// Shared types for the boot image copier.
package boot_copier_pkg;

    // Sequencer states; one byte moves per REQ -> CAP -> WRITE round.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_REQ,
        ST_HDR_CAP,
        ST_CHECK,
        ST_PAY_REQ,
        ST_PAY_CAP,
        ST_WRITE
    } bc_state_e;

endpackage

// File: rtl/bc_len_track.sv
// Length tracker: assembles the little-endian header one byte at a time,
// then counts down as payload bytes are handed to the target.
// Assumes shift_en is used exactly HDR_BYTES times after clear and dec only
// after that.
module bc_len_track #(
    parameter int unsigned HDR_BYTES = 4,
    parameter int unsigned MAX_LEN   = 57340,
    localparam int unsigned LEN_W    = 8 * HDR_BYTES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift_en,
    input  logic [7:0] byte_in,
    input  logic       dec,
    output logic       len_zero,
    output logic       too_long
);

    logic [LEN_W-1:0] len_q;

    // Header bytes enter at the top so the first byte ends up least significant.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            len_q <= '0;
        end else if (shift_en) begin
            len_q <= {byte_in, len_q[LEN_W-1:8]};
        end else if (dec && len_q != '0) begin
            len_q <= len_q - 1'b1;
        end
    end

    assign len_zero = (len_q == '0);
    assign too_long = (len_q > LEN_W'(MAX_LEN));

endmodule

// File: rtl/bc_src_port.sv
// Source address counter: restarts at the image base on clear and steps by
// one byte per issued read.
module bc_src_port #(
    parameter int unsigned SRC_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc,
    output logic [SRC_AW-1:0] addr
);

    // Next source offset to request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr <= '0;
        end else if (inc) begin
            addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/bc_tgt_port.sv
// Target write port: holds one byte, its address and the valid flag until
// the target accepts it, then moves the address on by one.
// Assumes load is never raised while a write is still pending.
module bc_tgt_port #(
    parameter int unsigned  TGT_AW     = 32,
    parameter logic [31:0]  ENTRY_ADDR = 32'h4020_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              load,
    input  logic [7:0]        byte_in,
    input  logic              ready,
    output logic              we,
    output logic [TGT_AW-1:0] addr,
    output logic [7:0]        wdata,
    output logic              accept
);

    assign accept = we && ready;

    // Write valid: set on load, cleared on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we <= 1'b0;
        end else if (load) begin
            we <= 1'b1;
        end else if (accept) begin
            we <= 1'b0;
        end
    end

    // Byte holding register, only written by load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata <= '0;
        end else if (load) begin
            wdata <= byte_in;
        end
    end

    // Target address: entry point on start, step after each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            addr <= TGT_AW'(ENTRY_ADDR);
        end else if (accept) begin
            addr <= addr + 1'b1;
        end
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !ready) |=> (we && $stable(addr) && $stable(wdata))) else $error("write dropped or changed while stalled"); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (addr == $past(addr) + 1'b1)) else $error("target address did not step by one"); // R3

endmodule

// File: rtl/boot_copier.sv
// Boot image copier top: reads a length header from the source image, copies
// that many bytes to consecutive target addresses from ENTRY_ADDR, then
// releases the target with run. Assumes a one-cycle source read latency and a
// target that accepts a byte in any cycle where tgt_we and tgt_ready are high.
module boot_copier
    import boot_copier_pkg::*;
#(
    parameter int unsigned SRC_AW     = 16,
    parameter int unsigned IMG_BYTES  = 57344,
    parameter int unsigned HDR_BYTES  = 4,
    parameter int unsigned TGT_AW     = 32,
    parameter logic [31:0] ENTRY_ADDR = 32'h4020_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              src_rd_en,
    output logic [SRC_AW-1:0] src_addr,
    input  logic [7:0]        src_rd_data,
    output logic              tgt_we,
    output logic [TGT_AW-1:0] tgt_addr,
    output logic [7:0]        tgt_wdata,
    input  logic              tgt_ready,
    output logic              run,
    output logic [TGT_AW-1:0] run_addr
);

    localparam int unsigned MAX_LEN = IMG_BYTES - HDR_BYTES;
    localparam int unsigned HIDX_W  = $clog2(HDR_BYTES + 1);

    bc_state_e         state_q, state_d;
    logic [HIDX_W-1:0] hidx_q;
    logic              start, hdr_shift, pay_load, len_zero, too_long, accept;
    logic              finish_ok, finish_err;

    assign busy     = (state_q != ST_IDLE);
    assign start    = (state_q == ST_IDLE) && go;
    assign run_addr = TGT_AW'(ENTRY_ADDR);

    assign src_rd_en = (state_q == ST_HDR_REQ) || (state_q == ST_PAY_REQ);
    assign hdr_shift = (state_q == ST_HDR_CAP);
    assign pay_load  = (state_q == ST_PAY_CAP);

    assign finish_err = (state_q == ST_CHECK) && too_long;
    assign finish_ok  = ((state_q == ST_CHECK) && !too_long && len_zero) ||
                        ((state_q == ST_WRITE) && accept && len_zero);

    bc_len_track #(
        .HDR_BYTES (HDR_BYTES),
        .MAX_LEN   (MAX_LEN)
    ) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .shift_en (hdr_shift),
        .byte_in  (src_rd_data),
        .dec      (pay_load),
        .len_zero (len_zero),
        .too_long (too_long)
    );

    bc_src_port #(
        .SRC_AW (SRC_AW)
    ) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .inc   (src_rd_en),
        .addr  (src_addr)
    );

    bc_tgt_port #(
        .TGT_AW     (TGT_AW),
        .ENTRY_ADDR (ENTRY_ADDR)
    ) u_tgt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (pay_load),
        .byte_in (src_rd_data),
        .ready   (tgt_ready),
        .we      (tgt_we),
        .addr    (tgt_addr),
        .wdata   (tgt_wdata),
        .accept  (accept)
    );

    // Next-state logic of the copy sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (go) state_d = ST_HDR_REQ;
            ST_HDR_REQ: state_d = ST_HDR_CAP;
            ST_HDR_CAP: state_d = (hidx_q == HIDX_W'(HDR_BYTES - 1)) ? ST_CHECK : ST_HDR_REQ;
            ST_CHECK:   state_d = (too_long || len_zero) ? ST_IDLE : ST_PAY_REQ;
            ST_PAY_REQ: state_d = ST_PAY_CAP;
            ST_PAY_CAP: state_d = ST_WRITE;
            ST_WRITE:   if (accept) state_d = len_zero ? ST_IDLE : ST_PAY_REQ;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Header byte index, restarted by every accepted GO.
    always_ff @(posedge clk) begin
        if (!rst_n || start) hidx_q <= '0;
        else if (hdr_shift)  hidx_q <= hidx_q + 1'b1;
    end

    // Completion flags: cleared by a new GO, set at the end of a copy.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            done  <= 1'b0;
            error <= 1'b0;
            run   <= 1'b0;
        end else if (finish_err) begin
            done  <= 1'b1;
            error <= 1'b1;
        end else if (finish_ok) begin
            done  <= 1'b1;
            run   <= 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tgt_we && !src_rd_en)) else $error("activity while idle"); // R1

    AST_RUN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (done && !busy && !error)) else $error("run with copy unfinished"); // R5

    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (done && !run)) else $error("error together with run"); // R7

    AST_SRC_IN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_en |-> (int'(src_addr) < int'(IMG_BYTES))) else $error("source read outside image"); // R7

    AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go) |=> (busy && !run && !done && !error)) else $error("GO did not restart"); // R9

endmodule

// File: tb/boot_copier_bench.sv
module boot_copier_bench;

    localparam logic [31:0] ENTRY = 32'h4020_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        busy, done, error, src_rd_en, tgt_we, run;
    logic [15:0] src_addr;
    logic [7:0]  src_rd_data = 8'h00;
    logic [31:0] tgt_addr, run_addr;
    logic [7:0]  tgt_wdata;
    logic        tgt_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int cycles = 0;
    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  mem [0:1023];
    logic [39:0] exp_q [$];

    always #10 clk = ~clk;

    boot_copier u_boot_copier (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done), .error(error),
        .src_rd_en(src_rd_en), .src_addr(src_addr), .src_rd_data(src_rd_data),
        .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .tgt_ready(tgt_ready), .run(run), .run_addr(run_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Source memory model: one cycle read latency.
    always @(posedge clk) begin
        if (src_rd_en) src_rd_data <= (src_addr < 16'd1024) ? mem[src_addr[9:0]] : 8'h00;
    end

    // Target ready model: always ready or pseudo-random stalls.
    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tgt_ready <= stall_mode ? lfsr[3] : 1'b1;
    end

    // Monitor: every accepted write must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && tgt_we && tgt_ready) begin
            wr_count++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected write addr", tgt_addr, 32'h0);
            end else begin
                logic [39:0] e;
                e = exp_q.pop_front();
                chk(tgt_addr == e[39:8], "R3", "write address", tgt_addr, e[39:8]);
                chk(tgt_wdata == e[7:0], "R4", "write data", {24'h0, tgt_wdata}, {24'h0, e[7:0]});
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic pulse_go();
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            if (done) break;
            @(negedge clk);
        end
    endtask

    // Driver: load image, push expected writes, start the copy.
    task automatic load_image(input logic [31:0] hdr, input int n, input int seed,
                              input bit expect_writes);
        for (int i = 0; i < 4; i++) mem[i] = hdr[8*i +: 8];
        for (int i = 0; i < n && i + 4 < 1024; i++) begin
            logic [7:0] b;
            b = 8'((i * 7 + seed * 13 + 5) & 8'hFF);
            mem[i + 4] = b;
            if (expect_writes) exp_q.push_back({ENTRY + 32'(i), b});
        end
    endtask

    task automatic check_end(input string req, input int n_exp, input int wr_before,
                             input bit exp_err);
        wait_done();
        chk(done == 1'b1, req, "done", {31'h0, done}, 32'h1);
        chk(busy == 1'b0, req, "busy", {31'h0, busy}, 32'h0);
        chk(error == exp_err, req, "error", {31'h0, error}, {31'h0, exp_err});
        chk(run == !exp_err, req, "run", {31'h0, run}, {31'h0, !exp_err});
        chk(wr_count - wr_before == n_exp, req, "write count", 32'(wr_count - wr_before), 32'(n_exp));
        chk(exp_q.size() == 0, req, "writes left", 32'(exp_q.size()), 32'h0);
        if (!exp_err) chk(run_addr == ENTRY, "R5", "run_addr", run_addr, ENTRY);
    endtask

    initial begin
        int w0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk({busy, done, error, run, tgt_we, src_rd_en} == 6'b0, "R1", "outputs in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, error, run, tgt_we, src_rd_en} == 6'b0, "R1", "outputs after reset", 0, 0);

        // R2/R3/R5: short copy, target always ready.
        load_image(32'd5, 5, 1, 1'b1);
        w0 = wr_count;
        pulse_go();
        chk(busy == 1'b1, "R2", "busy after GO", {31'h0, busy}, 32'h1);
        check_end("R5", 5, w0, 1'b0);

        // R9: new GO clears the flags at once; R4: copy under random stalls.
        stall_mode = 1'b1;
        load_image(32'd17, 17, 2, 1'b1);
        w0 = wr_count;
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        chk(run == 1'b0 && done == 1'b0, "R9", "flags cleared by GO", {30'h0, run, done}, 32'h0);
        check_end("R4", 17, w0, 1'b0);

        // R2: little-endian header, both low bytes non-zero (262 bytes).
        load_image(32'h0000_0106, 262, 3, 1'b1);
        w0 = wr_count;
        pulse_go();
        check_end("R2", 262, w0, 1'b0);

        // R8: GO pulses during a copy are ignored.
        load_image(32'd20, 20, 4, 1'b1);
        w0 = wr_count;
        pulse_go();
        repeat (12) @(negedge clk);
        pulse_go();
        repeat (9) @(negedge clk);
        pulse_go();
        check_end("R8", 20, w0, 1'b0);

        // R6: zero length.
        stall_mode = 1'b0;
        load_image(32'd0, 0, 5, 1'b0);
        w0 = wr_count;
        pulse_go();
        check_end("R6", 0, w0, 1'b0);

        // R7: one above the limit (57341) is refused.
        load_image(32'd57341, 8, 6, 1'b0);
        w0 = wr_count;
        pulse_go();
        check_end("R7", 0, w0, 1'b1);

        // R7: a very large length is refused too.
        load_image(32'hFFFF_FFFF, 8, 7, 1'b0);
        w0 = wr_count;
        pulse_go();
        check_end("R7", 0, w0, 1'b1);

        repeat (5) @(negedge clk);
        chk(wr_count == w0, "R7", "no late writes", 32'(wr_count), 32'(w0));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule